// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the datapath of a small 32-bit processor that spends several clock cycles on each instruction. An external control unit steers it one cycle at a time. The datapath holds:

- a program counter;
- an address register and a data register;
- an instruction register;
- a 32-entry register file.

All arithmetic goes through one shared ALU. The ALU takes one operand from an X selector and the other from a Y selector. It computes the next PC, effective addresses and register write-back values.

A single memory port serves both instruction fetch and data access. Its address comes from either the PC or the address register. Its write data is always the ALU result. Read data is captured by the data register or by the instruction register.

The block returns two things to the control unit: the opcode field of the instruction register, and a flag that is high when the ALU result is zero. Memory read data must be valid in the same cycle as the read command. It is captured at the next rising edge.

Top module: `mc_datapath`

## Requirements
- R1: The X operand is selected by `x_sel` as follows:
  - 0: PC
  - 1: the register file read port
  - 2: the address register
  - 3: the data register
  - 4: zero
  - 5, 6, 7: also zero
- R2: The Y operand is selected by `y_sel` as follows. The immediate is instruction bits 15:0.
  - 0: zero
  - 1: the constant 4
  - 2: the address register
  - 3: the sign-extended immediate
  - 4: the sign-extended immediate shifted left by two
  - 5: the zero-extended immediate
  - 6 and 7: zero
- R3: `alu_op` selects the ALU function: 2 adds X and Y, 6 subtracts Y from X, and 7 ORs them. Every other code gives a result of zero. The result appears on `mem_wdata`.
- R4: `zero` is high exactly when the ALU result is all zeros.
- R5: `mem_addr` carries the address register when `addr_sel` is 0 and the PC when it is 1.
- R6: The memory command `mem_cmd` drives the strobes:
  - 1: `mem_rd` high
  - 2: `mem_wr` high
  - 0 and 3: neither strobe
  - The two strobes are never high together.
- R7: On a rising edge, the PC loads the ALU result when `pc_we` is high, and the address register does so when `ad_we` is high. Otherwise each holds its value.
- R8: On a rising edge, the data register loads `mem_rdata` when `dt_we` is high, and the instruction register does so when `ir_we` is high. Otherwise each holds its value.
- R9: The register read port uses instruction bits 25:21 when `rf_rsel` is 0 and bits 20:16 when it is 1. A write with `rf_we` high stores the ALU result into the register named by bits 20:16 when `rf_wsel` is 0, or by bits 15:11 when it is 1.
- R10: Register 0 always reads as zero, and writes to it have no effect.
- R11: Reset is synchronous and active high, and it takes priority over the write enables.
  - It clears the PC, the address register, the data register and the instruction register.
  - `opcode` always shows instruction register bits 31:26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_we | input | 1 | PC load enable |
| ad_we | input | 1 | Address register load enable |
| dt_we | input | 1 | Data register load enable |
| ir_we | input | 1 | Instruction register load enable |
| rf_we | input | 1 | Register file write enable |
| rf_rsel | input | 1 | Read index select: 0 = bits 25:21, 1 = bits 20:16 |
| rf_wsel | input | 1 | Write index select: 0 = bits 20:16, 1 = bits 15:11 |
| x_sel | input | 3 | X operand source |
| y_sel | input | 3 | Y operand source |
| alu_op | input | 3 | ALU function code |
| addr_sel | input | 1 | Memory address source: 0 = address register, 1 = PC |
| mem_cmd | input | 2 | Memory command: 0 = none, 1 = read, 2 = write, 3 = none |
| mem_rdata | input | 32 | Memory read data, valid in the read cycle |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data (the ALU result) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| opcode | output | 6 | Instruction register bits 31:26 |
| zero | output | 1 | High when the ALU result is zero |

## Verification
Every internal register can be seen at the ports within the cycle it is selected:

- The PC and the address register show up on `mem_addr` right away.
- The data register, the address register, the PC and any register-file entry reach `mem_wdata` as soon as the X selector names them with an add of zero.

A wrong capture in a register therefore shows up in the first cycle after the bad edge in which the controller selects that register. A register-file entry corrupted by a write to the wrong index shows up only when that entry is next read. That is why the bench reads back every entry after loading it. It also checks the ALU result, the zero flag, the address and the strobes on every cycle of a long random run.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

    localparam int DW      = 32;
    localparam int NREGS   = 32;
    localparam int IMM_W   = 16;
    localparam int SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        XS_PC   = 3'd0,
        XS_RF   = 3'd1,
        XS_AD   = 3'd2,
        XS_DT   = 3'd3,
        XS_ZERO = 3'd4
    } xsrc_e;

    typedef enum logic [SEL_W-1:0] {
        YS_ZERO  = 3'd0,
        YS_FOUR  = 3'd1,
        YS_AD    = 3'd2,
        YS_SIMM  = 3'd3,
        YS_SIMM4 = 3'd4,
        YS_ZIMM  = 3'd5
    } ysrc_e;

    typedef enum logic [SEL_W-1:0] {
        OP_ADD = 3'd2,
        OP_SUB = 3'd6,
        OP_OR  = 3'd7
    } aluop_e;

    typedef enum logic [1:0] {
        MC_IDLE  = 2'd0,
        MC_READ  = 2'd1,
        MC_WRITE = 2'd2
    } memcmd_e;

    // instruction word as seen by the datapath
    typedef struct packed {
        logic [5:0]       opc;
        logic [4:0]       rs;
        logic [4:0]       rt;
        logic [IMM_W-1:0] imm;
    } instr_t;

    function automatic logic [4:0] rd_field(input instr_t i);
        return i.imm[15:11];
    endfunction

    function automatic logic [DW-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(DW-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [DW-1:0] zext_imm(input logic [IMM_W-1:0] v);
        return {{(DW-IMM_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
    parameter int W  = mcdp_pkg::DW,
    parameter int N  = mcdp_pkg::NREGS,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        if (g == 0) begin : g_hard_zero
            assign regs[g] = '0;
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (we && waddr == AW'(g))
                    regs[g] <= wdata;
            end
        end
    end

    assign rdata = regs[raddr];

    // R10: entry 0 reads as zero whatever was written to it
    p_r0_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (raddr == '0) |-> (rdata == '0));

endmodule

// File: rtl/mcdp_operands.sv
module mcdp_operands
    import mcdp_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [SEL_W-1:0] x_sel,
    input  logic [SEL_W-1:0] y_sel,
    input  logic [W-1:0]     pc,
    input  logic [W-1:0]     rf,
    input  logic [W-1:0]     ad,
    input  logic [W-1:0]     dt,
    input  logic [IMM_W-1:0] imm,
    output logic [W-1:0]     xop,
    output logic [W-1:0]     yop
);

    logic [W-1:0] simm;
    assign simm = sext_imm(imm);

    always_comb begin
        case (x_sel)
            XS_PC:   xop = pc;
            XS_RF:   xop = rf;
            XS_AD:   xop = ad;
            XS_DT:   xop = dt;
            default: xop = '0;
        endcase
    end

    always_comb begin
        case (y_sel)
            YS_FOUR:  yop = W'(4);
            YS_AD:    yop = ad;
            YS_SIMM:  yop = simm;
            YS_SIMM4: yop = simm << 2;
            YS_ZIMM:  yop = zext_imm(imm);
            default:  yop = '0;
        endcase
    end

endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
    import mcdp_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [SEL_W-1:0] op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     res,
    output logic             zero
);

    always_comb begin
        case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_OR:   res = a | b;
            default: res = '0;
        endcase
    end

    assign zero = ~|res;

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mcdp_pkg::*;
#(
    parameter int W = DW,
    parameter int N = NREGS,
    localparam int AW = $clog2(N)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pc_we,
    input  logic        ad_we,
    input  logic        dt_we,
    input  logic        ir_we,
    input  logic        rf_we,
    input  logic        rf_rsel,
    input  logic        rf_wsel,
    input  logic [2:0]  x_sel,
    input  logic [2:0]  y_sel,
    input  logic [2:0]  alu_op,
    input  logic        addr_sel,
    input  logic [1:0]  mem_cmd,
    input  logic [31:0] mem_rdata,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [5:0]  opcode,
    output logic        zero
);

    logic [W-1:0] pc, ad, dt;
    instr_t       ir;
    logic [W-1:0] rf_rdata, xop, yop, alu_res;
    logic [AW-1:0] rf_raddr, rf_waddr;

    // architectural registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
            ad <= '0;
            dt <= '0;
            ir <= '0;
        end else begin
            if (pc_we) pc <= alu_res;
            if (ad_we) ad <= alu_res;
            if (dt_we) dt <= mem_rdata;
            if (ir_we) ir <= instr_t'(mem_rdata);
        end
    end

    assign rf_raddr = rf_rsel ? AW'(ir.rt) : AW'(ir.rs);
    assign rf_waddr = rf_wsel ? AW'(rd_field(ir)) : AW'(ir.rt);

    mcdp_regfile #(.W(W), .N(N)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (alu_res),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    mcdp_operands #(.W(W)) u_opnd (
        .x_sel (x_sel),
        .y_sel (y_sel),
        .pc    (pc),
        .rf    (rf_rdata),
        .ad    (ad),
        .dt    (dt),
        .imm   (ir.imm),
        .xop   (xop),
        .yop   (yop)
    );

    mcdp_alu #(.W(W)) u_alu (
        .op   (alu_op),
        .a    (xop),
        .b    (yop),
        .res  (alu_res),
        .zero (zero)
    );

    assign mem_addr  = addr_sel ? pc : ad;
    assign mem_wdata = alu_res;
    assign mem_rd    = (mem_cmd == MC_READ);
    assign mem_wr    = (mem_cmd == MC_WRITE);
    assign opcode    = ir.opc;

    // R7: the PC holds its value unless it is enabled
    p_pc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !pc_we |=> $stable(pc));

    // R7: an enabled PC takes the ALU result
    p_pc_load_r7: assert property (@(posedge clk) disable iff (rst)
        pc_we |=> (pc == $past(alu_res)));

    // R7: an enabled address register takes the ALU result
    p_ad_load_r7: assert property (@(posedge clk) disable iff (rst)
        ad_we |=> (ad == $past(alu_res)));

    // R8: the data register captures the read data
    p_dt_load_r8: assert property (@(posedge clk) disable iff (rst)
        dt_we |=> (dt == $past(mem_rdata)));

    // R8: the instruction register captures the read data
    p_ir_load_r8: assert property (@(posedge clk) disable iff (rst)
        ir_we |=> (W'(ir) == $past(mem_rdata)));

    // R6: the read and write strobes are never high together
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R4: subtracting equal operands raises the zero flag
    p_sub_equal_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (alu_op == OP_SUB && xop == yop) |-> zero);

    // R11: one reset cycle clears the state registers
    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (pc == '0 && ad == '0 && dt == '0 && ir == '0));

endmodule

// File: tb/mc_datapath_test.sv
module mc_datapath_test;

    typedef struct packed {
        logic       pc_we, ad_we, dt_we, ir_we, rf_we, rsel, wsel;
        logic [2:0] xs, ys, op;
        logic       asel;
        logic [1:0] cmd;
    } ctl_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pc_we = 0, ad_we = 0, dt_we = 0, ir_we = 0, rf_we = 0;
    logic        rf_rsel = 0, rf_wsel = 0, addr_sel = 0;
    logic [2:0]  x_sel = 0, y_sel = 0, alu_op = 0;
    logic [1:0]  mem_cmd = 0;
    logic [31:0] mem_rdata = 0;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rd, mem_wr, zero;
    logic [5:0]  opcode;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference state
    logic [31:0] m_pc, m_ad, m_dt, m_ir;
    logic [31:0] m_rf [32];

    always #5 clk = ~clk;

    mc_datapath uut (
        .clk(clk), .rst(rst), .pc_we(pc_we), .ad_we(ad_we), .dt_we(dt_we),
        .ir_we(ir_we), .rf_we(rf_we), .rf_rsel(rf_rsel), .rf_wsel(rf_wsel),
        .x_sel(x_sel), .y_sel(y_sel), .alu_op(alu_op), .addr_sel(addr_sel),
        .mem_cmd(mem_cmd), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .opcode(opcode), .zero(zero)
    );

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] ref_rf(input ctl_t c);
        logic [4:0] idx = c.rsel ? m_ir[20:16] : m_ir[25:21];
        return (idx == 5'd0) ? 32'd0 : m_rf[idx];
    endfunction

    function automatic logic [31:0] ref_x(input ctl_t c);
        case (c.xs)
            3'd0: return m_pc;
            3'd1: return ref_rf(c);
            3'd2: return m_ad;
            3'd3: return m_dt;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] ref_y(input ctl_t c);
        case (c.ys)
            3'd1: return 32'd4;
            3'd2: return m_ad;
            3'd3: return sx(m_ir[15:0]);
            3'd4: return sx(m_ir[15:0]) << 2;
            3'd5: return {16'd0, m_ir[15:0]};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] ref_alu(input ctl_t c);
        logic [31:0] a = ref_x(c);
        logic [31:0] b = ref_y(c);
        case (c.op)
            3'd2: return a + b;
            3'd6: return a - b;
            3'd7: return a | b;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one controller cycle: drive, compare the combinational outputs, clock, update the reference
    task automatic step(input ctl_t c, input logic [31:0] rdata, input logic r, input string tag);
        logic [31:0] exp;
        logic [4:0]  widx;
        @(negedge clk);
        rst = r; pc_we = c.pc_we; ad_we = c.ad_we; dt_we = c.dt_we; ir_we = c.ir_we;
        rf_we = c.rf_we; rf_rsel = c.rsel; rf_wsel = c.wsel; x_sel = c.xs; y_sel = c.ys;
        alu_op = c.op; addr_sel = c.asel; mem_cmd = c.cmd; mem_rdata = rdata;
        #1;
        exp = ref_alu(c);
        chk(tag, mem_wdata, exp);
        chk("R4 zero", {31'd0, zero}, {31'd0, exp == 32'd0});
        chk("R5 addr", mem_addr, c.asel ? m_pc : m_ad);
        chk("R6 strobes", {30'd0, mem_rd, mem_wr}, {30'd0, c.cmd == 2'd1, c.cmd == 2'd2});
        chk("R11 opcode", {26'd0, opcode}, {26'd0, m_ir[31:26]});
        widx = c.wsel ? m_ir[15:11] : m_ir[20:16];
        @(posedge clk);
        if (c.rf_we && widx != 5'd0) m_rf[widx] = exp;
        if (r) begin
            m_pc = 0; m_ad = 0; m_dt = 0; m_ir = 0;
        end else begin
            if (c.pc_we) m_pc = exp;
            if (c.ad_we) m_ad = exp;
            if (c.dt_we) m_dt = rdata;
            if (c.ir_we) m_ir = rdata;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        ctl_t c;
        logic [31:0] rv;
        void'($urandom(32'd2024));
        repeat (2) @(posedge clk);
        m_pc = 0; m_ad = 0; m_dt = 0; m_ir = 0;
        for (int i = 0; i < 32; i++) m_rf[i] = 0;

        // R11: state after reset reads as zero
        c = '0; c.xs = 3'd0; c.op = 3'd2; c.asel = 1'b1;
        step(c, 32'h0, 1'b0, "R11 pc after reset");
        c = '0; c.xs = 3'd3; c.op = 3'd2;
        step(c, 32'h0, 1'b0, "R11 dt after reset");

        // R8/R9: load every register through IR and DT
        for (int k = 1; k < 32; k++) begin
            c = '0; c.ir_we = 1;
            step(c, {6'd0, 5'd0, 5'(k), 16'd0}, 1'b0, "R8 ir load");
            c = '0; c.dt_we = 1;
            step(c, $urandom, 1'b0, "R8 dt load");
            c = '0; c.xs = 3'd3; c.op = 3'd2; c.rf_we = 1;
            step(c, 32'h0, 1'b0, "R8 dt to alu");
        end
        // R9: read back via rs and rt; R2: immediate forms
        for (int k = 0; k < 32; k++) begin
            c = '0; c.ir_we = 1;
            step(c, {6'h23, 5'(k), 5'(31 - k), 16'h8000 | 16'(k * 1031)}, 1'b0, "R8 ir load");
            c = '0; c.xs = 3'd1; c.op = 3'd2;
            step(c, 32'h0, 1'b0, "R9 read rs");
            c.rsel = 1'b1;
            step(c, 32'h0, 1'b0, "R9 read rt");
            for (int s = 3; s < 6; s++) begin
                c = '0; c.xs = 3'd4; c.ys = 3'(s); c.op = 3'd2;
                step(c, 32'h0, 1'b0, "R2 immediate forms");
            end
        end
        // R9: write via rd field
        c = '0; c.ir_we = 1; step(c, {6'd0, 5'd7, 5'd2, 5'd7, 11'd0}, 1'b0, "R8 ir load");
        c = '0; c.dt_we = 1; step(c, 32'h1234_5678, 1'b0, "R8 dt load");
        c = '0; c.xs = 3'd3; c.op = 3'd2; c.rf_we = 1; c.wsel = 1;
        step(c, 32'h0, 1'b0, "R9 write rd");
        c = '0; c.xs = 3'd1; c.op = 3'd2;
        step(c, 32'h0, 1'b0, "R9 read rd target");
        // R10: write to register 0 is dropped
        c = '0; c.ir_we = 1; step(c, 32'h0, 1'b0, "R8 ir clear");
        c = '0; c.dt_we = 1; step(c, 32'hDEAD_BEEF, 1'b0, "R8 dt load");
        c = '0; c.xs = 3'd3; c.op = 3'd2; c.rf_we = 1;
        step(c, 32'h0, 1'b0, "R8 dt to alu");
        c = '0; c.xs = 3'd1; c.op = 3'd2;
        step(c, 32'h0, 1'b0, "R10 register 0 reads zero");
        // R7: PC and AD capture
        c = '0; c.xs = 3'd3; c.ys = 3'd1; c.op = 3'd2; c.pc_we = 1; c.ad_we = 1;
        step(c, 32'h0, 1'b0, "R7 load pc ad");
        c = '0; c.xs = 3'd0; c.op = 3'd2; c.asel = 1;
        step(c, 32'h0, 1'b0, "R7 pc value");
        c = '0; c.xs = 3'd2; c.op = 3'd2;
        step(c, 32'h0, 1'b0, "R7 ad value");
        c = '0; c.xs = 3'd0; c.ys = 3'd1; c.op = 3'd2; c.pc_we = 1; c.asel = 1;
        step(c, 32'h0, 1'b0, "R7 pc plus four");
        step(c, 32'h0, 1'b0, "R7 pc plus four");
        // R1: X sweep
        for (int s = 0; s < 8; s++) begin
            c = '0; c.xs = 3'(s); c.op = 3'd2;
            step(c, 32'h0, 1'b0, "R1 x select");
        end
        // R2: Y sweep
        for (int s = 0; s < 8; s++) begin
            c = '0; c.xs = 3'd4; c.ys = 3'(s); c.op = 3'd2;
            step(c, 32'h0, 1'b0, "R2 y select");
        end
        // R3: every ALU code
        for (int s = 0; s < 8; s++) begin
            c = '0; c.xs = 3'd2; c.ys = 3'd3; c.op = 3'(s);
            step(c, 32'h0, 1'b0, "R3 alu op");
        end
        c = '0; c.xs = 3'd2; c.ys = 3'd2; c.op = 3'd6;
        step(c, 32'h0, 1'b0, "R4 sub equal gives zero");
        // R6: every memory command
        for (int s = 0; s < 4; s++) begin
            c = '0; c.cmd = 2'(s); c.xs = 3'd3; c.op = 3'd2;
            step(c, 32'h0, 1'b0, "R6 write data");
        end
        // R11: reset overrides the enables
        c = '0; c.pc_we = 1; c.ad_we = 1; c.dt_we = 1; c.ir_we = 1; c.xs = 3'd3; c.ys = 3'd1; c.op = 3'd2;
        step(c, 32'hFFFF_FFFF, 1'b1, "R11 reset cycle");
        c = '0; c.xs = 3'd0; c.ys = 3'd0; c.op = 3'd7; c.asel = 1;
        step(c, 32'h0, 1'b0, "R11 pc cleared");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            rv = $urandom;
            c = rv[18:0];
            step(c, $urandom, ($urandom % 64) == 0, "R3 random");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule